// File: doc/BRIEF.md
# FP8 Quantizer with Delayed Scaling

This block turns a stream of BF16 values, one tensor at a time, into 8-bit floating-point codes. Each incoming value is multiplied by a scale factor that was fixed before the tensor started. The product is then rounded to nearest-even and clamped into one of two selectable FP8 layouts: 4 exponent bits with 3 mantissa bits, or 5 exponent bits with 2 mantissa bits. A code leaves the block one cycle after its input is accepted. The output never waits for statistics of the tensor being processed.

While the codes are produced, the block also keeps the largest finite input magnitude of the current tensor. When a beat flagged as last is accepted, that maximum goes into a fixed-depth window of recent maxima, and the oldest entry drops out. A sequential divider then computes the next scale as the format's largest finite value divided by the largest magnitude in the window. Input is stalled until the new scale is in place. The next tensor is therefore quantized with statistics gathered from the tensors before it, and no tensor is read twice.

Top module: `fp8_delayed_quant`

## Requirements
- R1: With `fmt_sel`=0 the code is sign in bit 7, a bias-7 exponent in bits 6:3 and a mantissa in bits 2:0. Rounding is to nearest, with ties to even mantissa (1.0 gives 0x38, 1.0625 gives 0x38, 1.1875 gives 0x3A).
- R2: With `fmt_sel`=1 the code is sign in bit 7, a bias-15 exponent in bits 6:2 and a mantissa in bits 1:0. Rounding is to nearest, ties to even (1.0 gives 0x3C, -1.125 gives 0xBC, 1.375 gives 0x3E).
- R3: A scaled magnitude above 448 (fmt 0) or 57344 (fmt 1), and any BF16 infinity, gives the largest finite code with the input's sign: 0x7E/0xFE or 0x7B/0xFB. No infinity code is ever produced.
- R4: A scaled value that rounds to zero gives a zero code with the input's sign. This covers values at or below half the smallest subnormal (exactly half rounds to even, so zero). BF16 inputs with a zero exponent field are treated as zero. Subnormal results carry an exponent field of 0.
- R5: A BF16 NaN gives 0x7F in fmt 0 and 0x7E in fmt 1. NaN and infinity inputs never change the tracked maximum.
- R6: For each accepted beat, `out_valid` is high and `out_code` holds its code in the following cycle. The scale used is the one in force when the tensor began.
- R7: Once a last beat is accepted, `amax_o` shows the BF16 magnitude (sign cleared) of the largest finite input of that tensor. Within a tensor the running maximum never decreases.
- R8: The window holds the maxima of the latest HIST_DEPTH tensors (default 16). A push discards the oldest entry.
- R9: The new scale is 448 (fmt 0) or 57344 (fmt 1) divided by the window maximum. The format is taken from the last beat. The mantissa is truncated to 15 fraction bits. `scale_o` uses the IEEE single layout with its low 8 fraction bits zero.
- R10: After reset `scale_o` is 0x3F800000 (1.0) and `amax_o` is 0. If every window entry is zero, the scale keeps its previous value.
- R11: `in_ready` is low from the cycle after a last beat is accepted until the new scale is committed. `scale_o` never changes while input is being accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can accept a beat |
| in_data | input | 16 | BF16 value |
| in_last | input | 1 | Beat closes the tensor |
| fmt_sel | input | 1 | 0: 4-bit exponent, 1: 5-bit exponent |
| out_valid | output | 1 | Code present |
| out_code | output | 8 | FP8 code |
| scale_o | output | 32 | Scale in force, single-precision bits |
| amax_o | output | 16 | Maximum magnitude of the latest completed tensor |

## Verification
Some checks run on every cycle. In-line properties confirm that the scale holds still while beats are accepted and that input stalls right after a closing beat. They also confirm that the running maximum only grows inside a tensor, that non-NaN inputs never produce a NaN or infinity pattern, that zero inputs give zero codes, and that each window push lands at the newest slot. Other behaviour only the bench's scenarios can show. This covers the exact codes at rounding ties, subnormal edges and saturation, and the scale values reached after the divider finishes. It also covers the scale holding when the window is all zero, and the point at which an old large maximum leaves the window after exactly HIST_DEPTH newer tensors.

// File: rtl/fp8dq_pkg.sv
package fp8dq_pkg;

    typedef enum logic {
        FMT_E4M3 = 1'b0,
        FMT_E5M2 = 1'b1
    } fmt_t;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_LOAD = 2'd1,
        ST_WAIT = 2'd2
    } ctl_st_t;

    localparam int BF_W    = 16;
    localparam int BF_MW   = 7;
    localparam int BF_BIAS = 127;
    localparam int MAG_W   = BF_W - 1;
    localparam int SEXP_W  = 10;
    localparam int SEXP_MIN = -126;
    localparam int SEXP_MAX = 127;

    // log2 of the largest finite value of each format, mantissa 1.75 in both
    function automatic int fmt_top_exp(fmt_t f);
        return (f == FMT_E5M2) ? 15 : 8;
    endfunction

endpackage

// File: rtl/fp8dq_encode.sv
module fp8dq_encode
    import fp8dq_pkg::*;
#(
    parameter int SFW = 15
) (
    input  logic [BF_W-1:0]          val_i,
    input  logic                     fmt_i,
    input  logic signed [SEXP_W-1:0] sexp_i,
    input  logic [SFW-1:0]           sfrac_i,
    output logic [7:0]               code_o
);
    localparam int PW = BF_MW + 1 + SFW + 1;
    localparam int XW = PW + 8;

    logic              sgn;
    logic [7:0]        ein;
    logic [PW-1:0]     prod, norm;
    logic [PW+XW-1:0]  ext;
    logic signed [12:0] e_un, emin, sh, rsh, bias, emaxf, field;
    logic [5:0]        rsh_c;
    logic [3:0]        q;
    logic              g, s, hi, lead, ovf, sat, sub;
    logic [4:0]        qr;
    logic [2:0]        mant, mmax;
    logic [6:0]        mag;

    always_comb begin
        sgn   = val_i[15];
        ein   = val_i[14:7];
        bias  = (fmt_i == FMT_E5M2) ? 13'sd15 : 13'sd7;
        emaxf = (fmt_i == FMT_E5M2) ? 13'sd30 : 13'sd15;
        mmax  = (fmt_i == FMT_E5M2) ? 3'd3 : 3'd6;

        prod = PW'({1'b1, val_i[6:0]}) * PW'({1'b1, sfrac_i});
        norm = prod[PW-1] ? prod : (prod << 1);

        e_un = $signed({5'b0, ein}) - 13'sd127
             + $signed({{(13-SEXP_W){sexp_i[SEXP_W-1]}}, sexp_i})
             + $signed({12'b0, prod[PW-1]});
        emin = 13'sd1 - bias;
        sub  = (e_un < emin);
        sh   = sub ? (emin - e_un) : 13'sd0;
        rsh  = 13'(PW - 1) - ((fmt_i == FMT_E5M2) ? 13'sd2 : 13'sd3) + sh;
        if (rsh > 13'(XW - 1)) rsh = 13'(XW - 1);
        rsh_c = 6'(rsh);

        ext = {norm, {XW{1'b0}}} >> rsh_c;
        q   = ext[XW+3:XW];
        hi  = |ext[PW+XW-1:XW+4];
        g   = ext[XW-1];
        s   = |ext[XW-2:0];
        qr  = {1'b0, q} + {4'b0, (g & (s | q[0]))};

        if (fmt_i == FMT_E5M2) begin
            mant = {1'b0, qr[1:0]};
            lead = qr[2];
            ovf  = qr[3];
        end else begin
            mant = qr[2:0];
            lead = qr[3];
            ovf  = qr[4];
        end

        if (sub)      field = $signed({12'b0, lead});
        else if (ovf) field = e_un + bias + 13'sd1;
        else          field = e_un + bias;

        sat = hi || (field > emaxf) || ((field == emaxf) && (mant > mmax));
        mag = (fmt_i == FMT_E5M2) ? 7'((field <<< 2) | 13'(mant))
                                  : 7'((field <<< 3) | 13'(mant));

        if (ein == 8'hFF && val_i[6:0] != 7'd0)
            code_o = (fmt_i == FMT_E5M2) ? 8'h7E : 8'h7F;
        else if (ein == 8'hFF || sat)
            code_o = {sgn, ((fmt_i == FMT_E5M2) ? 7'h7B : 7'h7E)};
        else if (ein == 8'h00)
            code_o = {sgn, 7'h00};
        else
            code_o = {sgn, mag};
    end

endmodule

// File: rtl/fp8dq_hist.sv
module fp8dq_hist
    import fp8dq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [MAG_W-1:0] data_i,
    output logic [MAG_W-1:0] max_o,
    output logic [MAG_W-1:0] newest_o
);
    typedef struct packed {
        logic [DEPTH-1:0][MAG_W-1:0] ent;
    } hist_s;

    hist_s h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (push_i) begin
            for (int i = DEPTH - 1; i > 0; i--) h_d.ent[i] = h_q.ent[i-1];
            h_d.ent[0] = data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

    always_comb begin
        max_o = '0;
        for (int i = 0; i < DEPTH; i++)
            if (h_q.ent[i] > max_o) max_o = h_q.ent[i];
    end

    assign newest_o = h_q.ent[0];

    // R8: a pushed maximum becomes the newest entry
    a_r8_push_newest: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> (newest_o == $past(data_i)));

    generate
        if (DEPTH > 1) begin : g_shift_chk
            // R8: entries move one slot older on every push
            a_r8_shift_older: assert property (@(posedge clk) disable iff (!rst_n)
                push_i |=> (h_q.ent[1] == $past(h_q.ent[0])));
        end
    endgenerate

endmodule

// File: rtl/fp8dq_div.sv
module fp8dq_div
    import fp8dq_pkg::*;
#(
    parameter int SFW = 15
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic                     fmt_i,
    input  logic [MAG_W-1:0]         den_i,
    output logic                     busy_o,
    output logic                     done_o,
    output logic signed [SEXP_W-1:0] exp_o,
    output logic [SFW-1:0]           frac_o
);
    localparam int QW  = SFW + 2;
    localparam int CW  = $clog2(QW + 1);
    localparam logic [8:0] NUM = 9'd224;   // 1.75 in units of 1/128

    typedef struct packed {
        logic              busy;
        logic              done;
        logic [8:0]        rem;
        logic [7:0]        den;
        logic [QW-1:0]     quo;
        logic [CW-1:0]     cnt;
        logic signed [10:0] base;
    } div_s;

    div_s r_d, r_q;
    logic       ge;
    logic [8:0] diff;
    logic signed [10:0] e_raw;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        ge       = (r_q.rem >= {1'b0, r_q.den});
        diff     = ge ? (r_q.rem - {1'b0, r_q.den}) : r_q.rem;
        if (start_i && !r_q.busy) begin
            r_d.busy = 1'b1;
            r_d.rem  = NUM;
            r_d.den  = {1'b1, den_i[6:0]};
            r_d.quo  = '0;
            r_d.cnt  = CW'(QW - 1);
            r_d.base = 11'(fmt_top_exp(fmt_t'(fmt_i)))
                     - ($signed({3'b0, den_i[14:7]}) - 11'sd127);
        end else if (r_q.busy) begin
            r_d.quo = {r_q.quo[QW-2:0], ge};
            r_d.rem = 9'(diff << 1);
            if (r_q.cnt == '0) begin
                r_d.busy = 1'b0;
                r_d.done = 1'b1;
            end else begin
                r_d.cnt = r_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        if (r_q.quo[QW-1]) begin
            frac_o = r_q.quo[QW-2:1];
            e_raw  = r_q.base;
        end else begin
            frac_o = r_q.quo[QW-3:0];
            e_raw  = r_q.base - 11'sd1;
        end
        if (e_raw > 11'(SEXP_MAX))      exp_o = SEXP_W'(SEXP_MAX);
        else if (e_raw < 11'(SEXP_MIN)) exp_o = SEXP_W'(SEXP_MIN);
        else                            exp_o = SEXP_W'(e_raw);
    end

    assign busy_o = r_q.busy;
    assign done_o = r_q.done;

    // R9: a result is reported for exactly one cycle
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R9: a new division is only requested while idle
    a_r9_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !busy_o);

endmodule

// File: rtl/fp8_delayed_quant.sv
module fp8_delayed_quant
    import fp8dq_pkg::*;
#(
    parameter int HIST_DEPTH = 16,
    parameter int SCALE_FW   = 15
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [15:0] in_data,
    input  logic        in_last,
    input  logic        fmt_sel,
    output logic        out_valid,
    output logic [7:0]  out_code,
    output logic [31:0] scale_o,
    output logic [15:0] amax_o
);
    localparam int PAD = 23 - SCALE_FW;

    typedef struct packed {
        ctl_st_t                st;
        logic [MAG_W-1:0]       run_amax;
        logic                   ov;
        logic [7:0]             code;
        logic                   onan;
        logic                   ozero;
        logic                   ofmt;
        logic                   fmt_last;
        logic signed [SEXP_W-1:0] sexp;
        logic [SCALE_FW-1:0]    sfrac;
    } top_s;

    top_s t_d, t_q;

    logic                     accept, push, is_nan, is_fin;
    logic [MAG_W-1:0]         cand, amax_nx, hist_max, hist_new;
    logic [7:0]               enc_code;
    logic                     div_start, div_busy, div_done;
    logic signed [SEXP_W-1:0] div_exp;
    logic [SCALE_FW-1:0]      div_frac;

    fp8dq_encode #(.SFW(SCALE_FW)) u_enc (
        .val_i  (in_data),
        .fmt_i  (fmt_sel),
        .sexp_i (t_q.sexp),
        .sfrac_i(t_q.sfrac),
        .code_o (enc_code)
    );

    fp8dq_hist #(.DEPTH(HIST_DEPTH)) u_hist (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push),
        .data_i  (amax_nx),
        .max_o   (hist_max),
        .newest_o(hist_new)
    );

    fp8dq_div #(.SFW(SCALE_FW)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(div_start),
        .fmt_i  (t_q.fmt_last),
        .den_i  (hist_max),
        .busy_o (div_busy),
        .done_o (div_done),
        .exp_o  (div_exp),
        .frac_o (div_frac)
    );

    always_comb begin
        in_ready  = (t_q.st == ST_RUN);
        accept    = in_valid && in_ready;
        push      = accept && in_last;
        is_nan    = (in_data[14:7] == 8'hFF) && (in_data[6:0] != 7'd0);
        is_fin    = (in_data[14:7] != 8'hFF) && (in_data[14:7] != 8'h00);
        cand      = is_fin ? in_data[14:0] : '0;
        amax_nx   = (cand > t_q.run_amax) ? cand : t_q.run_amax;
        div_start = (t_q.st == ST_LOAD) && (hist_max != '0);

        t_d    = t_q;
        t_d.ov = accept;
        if (accept) begin
            t_d.code  = enc_code;
            t_d.onan  = is_nan;
            t_d.ozero = (in_data[14:7] == 8'h00);
            t_d.ofmt  = fmt_sel;
        end

        case (t_q.st)
            ST_RUN: begin
                if (accept) begin
                    t_d.run_amax = in_last ? '0 : amax_nx;
                    if (in_last) begin
                        t_d.fmt_last = fmt_sel;
                        t_d.st       = ST_LOAD;
                    end
                end
            end
            ST_LOAD: t_d.st = (hist_max == '0) ? ST_RUN : ST_WAIT;
            ST_WAIT: begin
                if (div_done) begin
                    t_d.sexp  = div_exp;
                    t_d.sfrac = div_frac;
                    t_d.st    = ST_RUN;
                end
            end
            default: t_d.st = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '{st: ST_RUN, default: '0};
        else        t_q <= t_d;
    end

    assign out_valid = t_q.ov;
    assign out_code  = t_q.code;
    assign scale_o   = {1'b0, 8'(t_q.sexp + SEXP_W'(BF_BIAS)), t_q.sfrac, {PAD{1'b0}}};
    assign amax_o    = {1'b0, hist_new};

    // R11: input stalls in the cycle after a closing beat
    a_r11_stall_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && in_last) |=> !in_ready);
    // R11: the scale is frozen across consecutive accepting cycles
    a_r11_scale_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && $past(in_ready)) |-> $stable(scale_o));
    // R7: the running maximum only grows within a tensor
    a_r7_amax_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        !(accept && in_last) |=> (t_q.run_amax >= $past(t_q.run_amax)));
    // R5: a non-NaN input never yields a NaN code in the 4-bit exponent layout
    a_r5_no_nan_e4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !t_q.onan && !t_q.ofmt) |-> (out_code[6:0] != 7'h7F));
    // R3: no all-ones exponent for non-NaN input in the 5-bit exponent layout
    a_r3_no_inf_e5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !t_q.onan && t_q.ofmt) |-> (out_code[6:2] != 5'h1F));
    // R4: a zero-exponent input gives a zero magnitude
    a_r4_zero_in_zero_out: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && t_q.ozero) |-> (out_code[6:0] == 7'h00));
    // R11: the divider only runs while input is stalled
    a_r11_div_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        div_busy |-> !in_ready);

endmodule

// File: tb/fp8_delayed_quant_bench.sv
module fp8_delayed_quant_bench;
    localparam int CLK_P = 10;
    localparam int NV    = 27;

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 1'b0, in_last = 1'b0, fmt_sel = 1'b0;
    logic [15:0] in_data = '0;
    logic in_ready, out_valid;
    logic [7:0] out_code;
    logic [31:0] scale_o;
    logic [15:0] amax_o;
    int total = 0, bad = 0;
    bit finished = 0;

    always #(CLK_P/2) clk = ~clk;

    fp8_delayed_quant u_fp8_delayed_quant (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_last(in_last), .fmt_sel(fmt_sel),
        .out_valid(out_valid), .out_code(out_code), .scale_o(scale_o), .amax_o(amax_o)
    );

    // {requirement, format, bf16 input, expected code} at scale 1.0
    localparam logic [28:0] VEC [NV] = '{
        {4'd1, 1'b0, 16'h3F80, 8'h38},  // R1 1.0
        {4'd1, 1'b0, 16'hC000, 8'hC0},  // R1 -2.0
        {4'd1, 1'b0, 16'h43E0, 8'h7E},  // R1 448 exactly
        {4'd3, 1'b0, 16'h43FA, 8'h7E},  // R3 500 saturates
        {4'd3, 1'b0, 16'h4974, 8'h7E},  // R3 large positive
        {4'd3, 1'b0, 16'hC974, 8'hFE},  // R3 large negative
        {4'd1, 1'b0, 16'h3F88, 8'h38},  // R1 tie to even down
        {4'd1, 1'b0, 16'h3F98, 8'h3A},  // R1 tie to even up
        {4'd4, 1'b0, 16'h3B00, 8'h01},  // R4 smallest subnormal
        {4'd4, 1'b0, 16'h3A80, 8'h00},  // R4 half of it, to even zero
        {4'd4, 1'b0, 16'h3AC0, 8'h01},  // R4 three quarters rounds up
        {4'd4, 1'b0, 16'hBA00, 8'h80},  // R4 negative flush
        {4'd4, 1'b0, 16'h3C00, 8'h04},  // R4 subnormal 2^-7
        {4'd4, 1'b0, 16'h3C70, 8'h08},  // R4 rounds into smallest normal
        {4'd4, 1'b0, 16'h0001, 8'h00},  // R4 bf16 subnormal as zero
        {4'd5, 1'b0, 16'h7FC0, 8'h7F},  // R5 NaN
        {4'd3, 1'b0, 16'h7F80, 8'h7E},  // R3 +inf
        {4'd3, 1'b0, 16'hFF80, 8'hFE},  // R3 -inf
        {4'd2, 1'b1, 16'h3F80, 8'h3C},  // R2 1.0
        {4'd2, 1'b1, 16'h4760, 8'h7B},  // R2 57344 exactly
        {4'd3, 1'b1, 16'h4780, 8'h7B},  // R3 65536 saturates
        {4'd2, 1'b1, 16'hBF90, 8'hBC},  // R2 tie to even down
        {4'd2, 1'b1, 16'h3FB0, 8'h3E},  // R2 tie to even up
        {4'd5, 1'b1, 16'hFFC1, 8'h7E},  // R5 NaN
        {4'd4, 1'b1, 16'h3780, 8'h01},  // R4 smallest subnormal
        {4'd3, 1'b1, 16'hFF80, 8'hFB},  // R3 -inf
        {4'd1, 1'b0, 16'h3F80, 8'h38}   // R1 closing beat
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic real pow2(input int k);
        real r = 1.0;
        if (k >= 0) for (int i = 0; i < k; i++) r = r * 2.0;
        else        for (int i = 0; i < -k; i++) r = r / 2.0;
        return r;
    endfunction

    function automatic real bf_val(input logic [15:0] b);
        return (1.0 + real'(b[6:0]) / 128.0) * pow2(int'(b[14:7]) - 127);
    endfunction

    // R9: format maximum over window maximum, fraction truncated to 15 bits
    function automatic logic [31:0] exp_scale(input logic f, input logic [15:0] am);
        real r = (f ? 57344.0 : 448.0) / bf_val(am);
        int e = 0;
        int fr;
        while (r / pow2(e) >= 2.0) e++;
        while (r / pow2(e) < 1.0) e--;
        fr = int'($floor((r / pow2(e) - 1.0) * 32768.0));
        return {1'b0, 8'(e + 127), 15'(fr), 8'h00};
    endfunction

    task automatic wait_ready();
        for (int i = 0; i < 200 && !in_ready; i++) @(negedge clk);
    endtask

    task automatic send(input logic f, input logic [15:0] d, input logic lst,
                        input logic chk, input logic [7:0] exp, input string tag);
        wait_ready();
        in_valid = 1'b1; in_data = d; in_last = lst; fmt_sel = f;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        if (chk) begin
            check({tag, " R6 valid"}, 32'(out_valid), 32'd1);
            check(tag, 32'(out_code), 32'(exp));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL R11 watchdog expired: actual hung expected done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] big_scale;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check("R10 reset scale", scale_o, 32'h3F800000);
        check("R10 reset amax", 32'(amax_o), 32'h0);
        check("R10 reset ready", 32'(in_ready), 32'd1);
        check("R6 reset out_valid", 32'(out_valid), 32'd0);

        // R10 all-zero window keeps the scale; R5 NaN excluded from maximum
        send(1'b0, 16'h0000, 1'b0, 1'b1, 8'h00, "R4 zero");
        send(1'b0, 16'h7FC0, 1'b1, 1'b1, 8'h7F, "R5 NaN");
        check("R11 stall after last", 32'(in_ready), 32'd0);
        wait_ready();
        check("R10 zero window scale", scale_o, 32'h3F800000);
        check("R5 NaN amax", 32'(amax_o), 32'h0);

        // Table walk at scale 1.0, closed on its final entry
        for (int i = 0; i < NV; i++)
            send(VEC[i][24], VEC[i][23:8], (i == NV - 1), 1'b1, VEC[i][7:0],
                 $sformatf("R%0d vector %0d", VEC[i][28:25], i));
        check("R11 stall after table", 32'(in_ready), 32'd0);
        wait_ready();
        check("R7 table amax", 32'(amax_o), 32'h4974);
        big_scale = exp_scale(1'b0, 16'h4974);
        check("R9 scale from table", scale_o, big_scale);

        // R8 the large maximum survives 15 newer tensors and leaves on the 16th
        for (int i = 0; i < 16; i++) begin
            send(1'b0, 16'h4000, 1'b1, 1'b0, 8'h00, "R8");
            wait_ready();
            if (i == 14) check("R8 old max still held", scale_o, big_scale);
        end
        check("R8 old max evicted", scale_o, 32'h43600000);

        // Scale 224: R6 codes use the committed scale, R3 saturation
        send(1'b0, 16'h3F80, 1'b0, 1'b1, 8'h76, "R6 1.0 at scale 224");
        check("R11 scale fixed mid tensor", scale_o, 32'h43600000);
        send(1'b0, 16'h4080, 1'b0, 1'b1, 8'h7E, "R3 4.0 at scale 224");
        send(1'b0, 16'hBF00, 1'b1, 1'b1, 8'hEE, "R6 -0.5 at scale 224");
        wait_ready();
        check("R9 scale 448/4", scale_o, 32'h42E00000);
        check("R7 amax 4.0", 32'(amax_o), 32'h4080);

        // Scale 112 with the 5-bit exponent layout; closing format picks 57344
        send(1'b1, 16'h3F80, 1'b0, 1'b1, 8'h57, "R2 1.0 at scale 112");
        send(1'b1, 16'h4480, 1'b1, 1'b1, 8'h7B, "R3 1024 at scale 112");
        wait_ready();
        check("R9 scale 57344/1024", scale_o, 32'h42600000);
        check("R7 amax 1024", 32'(amax_o), 32'h4480);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule